// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block holds eight 80-bit registers that can be reached in two ways. A floating-point view treats the registers as a circular stack. A 3-bit top pointer moves on push and pop, and a logical slot number is added to it to find the physical register. A packed-integer (SIMD) view reaches the same registers directly by number and only sees their low 64 bits, which form the mantissa field. Both views share one set of flops, so a value written through one view can be read through the other on the next cycle.

A SIMD write puts its 64-bit operand into the mantissa field and fills the 16 sign/exponent bits above it with ones. In floating-point terms that pattern is a NaN or an infinity. A per-register tag output reports every entry whose top 16 bits are all ones, so software or a downstream unit can tell SIMD contents from ordinary floating-point numbers. Each view has one write port and two read ports. Reads are combinational from the registered storage. All controls are plain strobes. There is no valid/ready back-pressure: every write and every push or pop is accepted in the cycle it is presented.

Top module: `aliasreg_file`

## Requirements
- R1: After reset is released (rst_n low, active low), every entry reads as zero through both views, `top_ptr` is 0 and `simd_tag` is 8'h00.
- R2: A SIMD write to register k stores the 64-bit operand in bits 63:0 of physical entry k and sets bits 79:64 of that entry to 16'hFFFF.
- R3: A SIMD read port given index k returns bits 63:0 of physical entry k, whatever the top pointer holds.
- R4: A floating-point read or write at logical slot i addresses physical entry (top_ptr + i) mod 8. A floating-point write stores all 80 bits as given.
- R5: When `fp_push` is high alone, the top pointer decrements modulo 8. When `fp_pop` is high alone, it increments modulo 8. When both are high or both are low, it holds. SIMD writes never move it.
- R6: A floating-point write in the same cycle as a push or pop uses the top pointer value from before that cycle's update.
- R7: A read of an entry that is being written in the same cycle returns the old contents. The new contents appear on both views from the next cycle.
- R8: When both views write the same physical entry in one cycle, the SIMD write wins: the entry becomes {16'hFFFF, simd_wdata}.
- R9: `simd_tag[k]` is 1 exactly when bits 79:64 of physical entry k are all ones. This holds whichever view wrote the entry.
- R10: `top_ptr` shows the current top-of-stack pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fp_we | input | 1 | Floating-point write strobe |
| fp_wr_slot | input | 3 | Logical stack slot to write |
| fp_wdata | input | 80 | Floating-point write value |
| fp_push | input | 1 | Decrement top pointer |
| fp_pop | input | 1 | Increment top pointer |
| fp_ra_slot | input | 3 | Logical slot, FP read port A |
| fp_ra_data | output | 80 | FP read port A data |
| fp_rb_slot | input | 3 | Logical slot, FP read port B |
| fp_rb_data | output | 80 | FP read port B data |
| simd_we | input | 1 | SIMD write strobe |
| simd_wr_reg | input | 3 | Physical register to write |
| simd_wdata | input | 64 | SIMD write value |
| simd_ra_reg | input | 3 | Register, SIMD read port A |
| simd_ra_data | output | 64 | SIMD read port A data |
| simd_rb_reg | input | 3 | Register, SIMD read port B |
| simd_rb_data | output | 64 | SIMD read port B data |
| top_ptr | output | 3 | Current top-of-stack pointer |
| simd_tag | output | 8 | Per-entry all-ones-upper flag |

## Verification
The bench goes after five corner cases.
- Wrap of the top pointer across 0 and 7. A design that mishandles it would place stack slots on the wrong physical entries once the pointer crosses the boundary.
- A push or pop issued together with a floating-point write. A design that uses the updated pointer writes one entry off.
- A collision where both views write the same register. Letting the floating-point write win would leave a plain value where SIMD data was expected.
- A read of an entry in the cycle it is written, which must return the old value.
- An 80-bit floating-point write whose top bits happen to be all ones. The tag must follow the contents, not the view used; a design that tracks the writing view instead would miss this case.

// File: rtl/aliasreg_pkg.sv
package aliasreg_pkg;
  localparam int unsigned N_ENT   = 8;
  localparam int unsigned MANT_W  = 64;
  localparam int unsigned UPPER_W = 16;
  localparam int unsigned ENT_W   = MANT_W + UPPER_W;
  localparam int unsigned IDX_W   = $clog2(N_ENT);

  typedef logic [ENT_W-1:0] ent_t;
  typedef logic [MANT_W-1:0] mant_t;
  typedef logic [IDX_W-1:0] idx_t;

  function automatic ent_t simd_pack(input mant_t m);
    return {{UPPER_W{1'b1}}, m};
  endfunction
endpackage

// File: rtl/aliasreg_tos.sv
module aliasreg_tos
  import aliasreg_pkg::*;
#(
  parameter int unsigned NPORT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  idx_t slot [NPORT],
  output idx_t phys [NPORT],
  output idx_t top
);
  idx_t top_q;

  always_ff @(posedge clk) begin
    if (!rst_n) top_q <= '0;
    else if (push && !pop) top_q <= top_q - idx_t'(1);
    else if (pop && !push) top_q <= top_q + idx_t'(1);
  end

  assign top = top_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    assign phys[p] = top_q + slot[p];
  end

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> top_q == idx_t'($past(top_q) - idx_t'(1))); // R5
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> top_q == idx_t'($past(top_q) + idx_t'(1))); // R5
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push == pop) |=> $stable(top_q)); // R5
endmodule

// File: rtl/aliasreg_store.sv
module aliasreg_store
  import aliasreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fp_we,
  input  idx_t  fp_addr,
  input  ent_t  fp_data,
  input  logic  simd_we,
  input  idx_t  simd_addr,
  input  mant_t simd_data,
  output ent_t  ent [N_ENT]
);
  ent_t mem_q [N_ENT];

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    logic hit_fp, hit_simd;
    assign hit_fp   = fp_we   && (fp_addr   == idx_t'(k));
    assign hit_simd = simd_we && (simd_addr == idx_t'(k));

    always_ff @(posedge clk) begin
      if (!rst_n) mem_q[k] <= '0;
      else if (hit_simd) mem_q[k] <= simd_pack(simd_data);
      else if (hit_fp) mem_q[k] <= fp_data;
    end

    assign ent[k] = mem_q[k];
  end

  AST_SIMD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    simd_we |=> ent[$past(simd_addr)][ENT_W-1:MANT_W] == '1); // R2
  AST_SIMD_MANT: assert property (@(posedge clk) disable iff (!rst_n)
    simd_we |=> ent[$past(simd_addr)][MANT_W-1:0] == $past(simd_data)); // R2
  AST_FP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_we && !(simd_we && simd_addr == fp_addr)) |=> ent[$past(fp_addr)] == $past(fp_data)); // R4
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_we && simd_we && simd_addr == fp_addr) |=> ent[$past(fp_addr)] == {{UPPER_W{1'b1}}, $past(simd_data)}); // R8
endmodule

// File: rtl/aliasreg_classify.sv
module aliasreg_classify
  import aliasreg_pkg::*;
(
  input  ent_t ent [N_ENT],
  output logic [N_ENT-1:0] tag
);
  for (genvar k = 0; k < N_ENT; k++) begin : g_tag
    assign tag[k] = &ent[k][ENT_W-1:MANT_W];
  end

  always_comb begin
    for (int k = 0; k < N_ENT; k++) begin
      AST_TAG_MATCH: assert (tag[k] == (ent[k][ENT_W-1:MANT_W] == '1)); // R9
    end
  end
endmodule

// File: rtl/aliasreg_file.sv
module aliasreg_file
  import aliasreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fp_we,
  input  logic [2:0]  fp_wr_slot,
  input  logic [79:0] fp_wdata,
  input  logic        fp_push,
  input  logic        fp_pop,
  input  logic [2:0]  fp_ra_slot,
  output logic [79:0] fp_ra_data,
  input  logic [2:0]  fp_rb_slot,
  output logic [79:0] fp_rb_data,
  input  logic        simd_we,
  input  logic [2:0]  simd_wr_reg,
  input  logic [63:0] simd_wdata,
  input  logic [2:0]  simd_ra_reg,
  output logic [63:0] simd_ra_data,
  input  logic [2:0]  simd_rb_reg,
  output logic [63:0] simd_rb_data,
  output logic [2:0]  top_ptr,
  output logic [7:0]  simd_tag
);
  localparam int unsigned P_WR = 0;
  localparam int unsigned P_RA = 1;
  localparam int unsigned P_RB = 2;
  localparam int unsigned NPORT = 3;

  idx_t slot [NPORT];
  idx_t phys [NPORT];
  idx_t top;
  ent_t ent [N_ENT];

  assign slot[P_WR] = fp_wr_slot;
  assign slot[P_RA] = fp_ra_slot;
  assign slot[P_RB] = fp_rb_slot;

  aliasreg_tos #(.NPORT(NPORT)) u_tos (
    .clk(clk), .rst_n(rst_n), .push(fp_push), .pop(fp_pop),
    .slot(slot), .phys(phys), .top(top)
  );

  aliasreg_store u_store (
    .clk(clk), .rst_n(rst_n),
    .fp_we(fp_we), .fp_addr(phys[P_WR]), .fp_data(fp_wdata),
    .simd_we(simd_we), .simd_addr(simd_wr_reg), .simd_data(simd_wdata),
    .ent(ent)
  );

  aliasreg_classify u_cls (.ent(ent), .tag(simd_tag));

  assign fp_ra_data   = ent[phys[P_RA]];
  assign fp_rb_data   = ent[phys[P_RB]];
  assign simd_ra_data = ent[simd_ra_reg][MANT_W-1:0];
  assign simd_rb_data = ent[simd_rb_reg][MANT_W-1:0];
  assign top_ptr      = top;

  AST_SIMD_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (simd_we && !fp_push && !fp_pop) |=> $stable(top_ptr)); // R5
  AST_CROSS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    (simd_we && simd_ra_reg == simd_wr_reg && !fp_we) |=> simd_ra_data == $past(simd_wdata) || simd_ra_reg != $past(simd_wr_reg)); // R7
endmodule

// File: tb/aliasreg_file_test.sv
module aliasreg_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // op: 0 FP write, 1 SIMD write, 2 push, 3 pop, 4 push and pop
  localparam logic [85:0] VEC [NV] = '{
    {3'd1, 3'd0, 80'h0000_0123456789ABCDEF},
    {3'd0, 3'd1, 80'h4000_8000000000000000},
    {3'd2, 3'd0, 80'h0},
    {3'd0, 3'd0, 80'hC001_A5A5A5A5A5A5A5A5},
    {3'd1, 3'd7, 80'h0000_FEDCBA9876543210},
    {3'd2, 3'd0, 80'h0},
    {3'd0, 3'd2, 80'hFFFF_0000111122223333},
    {3'd4, 3'd0, 80'h0},
    {3'd3, 3'd0, 80'h0},
    {3'd3, 3'd0, 80'h0},
    {3'd3, 3'd0, 80'h0},
    {3'd0, 3'd7, 80'h7FFE_1111111111111111},
    {3'd1, 3'd3, 80'h0000_0000000000000001},
    {3'd0, 3'd3, 80'h3FFF_C000000000000000}
  };

  logic clk = 0, rst_n = 0;
  logic fp_we = 0, fp_push = 0, fp_pop = 0, simd_we = 0;
  logic [2:0] fp_wr_slot = 0, fp_ra_slot = 0, fp_rb_slot = 0;
  logic [2:0] simd_wr_reg = 0, simd_ra_reg = 0, simd_rb_reg = 0;
  logic [79:0] fp_wdata = 0, fp_ra_data, fp_rb_data;
  logic [63:0] simd_wdata = 0, simd_ra_data, simd_rb_data;
  logic [2:0] top_ptr;
  logic [7:0] simd_tag;

  logic [79:0] m [8];
  logic [2:0] mtop;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aliasreg_file uut (.*);

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] t;
    for (int i = 0; i < 8; i++) begin
      fp_ra_slot = 3'(i); fp_rb_slot = 3'(7 - i);
      simd_ra_reg = 3'(i); simd_rb_reg = 3'(7 - i);
      #1;
      chk({req, " R4 fpA"}, fp_ra_data, m[3'(mtop + 3'(i))]);
      chk({req, " R4 fpB"}, fp_rb_data, m[3'(mtop + 3'(7 - i))]);
      chk({req, " R3 simdA"}, {16'h0, simd_ra_data}, {16'h0, m[i][63:0]});
      chk({req, " R3 simdB"}, {16'h0, simd_rb_data}, {16'h0, m[7 - i][63:0]});
    end
    for (int k = 0; k < 8; k++) t[k] = (m[k][79:64] == 16'hFFFF);
    chk({req, " R9 tag"}, {72'h0, simd_tag}, {72'h0, t});
    chk({req, " R10 top"}, {77'h0, top_ptr}, {77'h0, mtop});
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    fp_we = 0; simd_we = 0; fp_push = 0; fp_pop = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m[k] = '0;
    mtop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op, ix; logic [79:0] d;
      {op, ix, d} = VEC[v];
      case (op)
        3'd0: begin fp_we = 1; fp_wr_slot = ix; fp_wdata = d; m[3'(mtop + ix)] = d; end
        3'd1: begin simd_we = 1; simd_wr_reg = ix; simd_wdata = d[63:0]; m[ix] = {16'hFFFF, d[63:0]}; end // R2
        3'd2: begin fp_push = 1; mtop = mtop - 3'd1; end // R5
        3'd3: begin fp_pop = 1; mtop = mtop + 3'd1; end // R5
        default: begin fp_push = 1; fp_pop = 1; end
      endcase
      step();
      check_all("vector R2 R5");
    end

    // R6: push together with FP write uses the old top
    fp_we = 1; fp_push = 1; fp_wr_slot = 3'd1; fp_wdata = 80'h1234_5555666677778888;
    m[3'(mtop + 3'd1)] = fp_wdata; mtop = mtop - 3'd1;
    step(); check_all("R6 push+write");

    // R7: same-cycle read returns old value, next cycle shows new on FP view
    simd_we = 1; simd_wr_reg = 3'd5; simd_wdata = 64'hDEAD_BEEF_0BAD_F00D;
    simd_ra_reg = 3'd5; fp_ra_slot = 3'(3'd5 - mtop);
    #1;
    chk("R7 old simd", {16'h0, simd_ra_data}, {16'h0, m[5][63:0]});
    chk("R7 old fp", fp_ra_data, m[5]);
    m[5] = {16'hFFFF, simd_wdata};
    step();
    simd_ra_reg = 3'd5; fp_ra_slot = 3'(3'd5 - mtop); #1;
    chk("R7 new fp", fp_ra_data, m[5]);

    // R8: collision on the same physical entry, SIMD wins
    fp_we = 1; fp_wr_slot = 3'(3'd2 - mtop); fp_wdata = 80'h0001_0000000000000002;
    simd_we = 1; simd_wr_reg = 3'd2; simd_wdata = 64'h0F0F_0F0F_0F0F_0F0F;
    m[2] = {16'hFFFF, simd_wdata};
    step(); check_all("R8 collision");

    // R5: SIMD write leaves the top pointer alone
    simd_we = 1; simd_wr_reg = 3'd6; simd_wdata = 64'h6;
    m[6] = {16'hFFFF, 64'h6};
    step(); check_all("R5 simd keeps top");

    // R1: reset again clears everything
    rst_n = 0; step(); step(); rst_n = 1;
    for (int k = 0; k < 8; k++) m[k] = '0;
    mtop = 0;
    check_all("R1 re-reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule